// File: doc/BRIEF.md
# Console Memory Read Decoder

This block sits between a handheld console CPU and the memories of its 16-bit address map. For each accepted read it works out which memory owns the address, raises a one-hot select strobe for that memory together with the local offset inside it, and captures the byte the memory returns on a shared return-data input. The captured byte is presented one cycle later on a response port. Some reads return a fixed value and touch no memory: reads blocked by a running sprite-table DMA, sprite-table reads while the video unit owns that table, the unusable hole, and an external-RAM window with nothing behind it.

The memories, the cartridge bank logic and the DMA engine live outside the block. Only their status flags come in: DMA running and its source page, console model, video mode, and the external-RAM enables. Requests and responses use valid/ready handshakes. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle, so the block holds one read in flight. A response stays valid, with stable data, until `rsp_ready` takes it.

Top module: `cpu_read_steer`

## Requirements
- R1: Address bits [15:12] of 0x0–0x3 select the fixed ROM (src_sel bit 0) and 0x4–0x7 select the switchable ROM (bit 1), with offset addr[13:0].
- R2: Address bits [15:12] of 0x8–0x9 select video RAM (src_sel bit 2) with offset addr[12:0].
- R3: In 0xA000–0xBFFF the first enabled source in this order wins: clock registers when clk_reg_en (bit 3), the mapper handler when mapper_rd_en (bit 4), cartridge SRAM when sram_en and sram_present (bit 5). If none is enabled, the read returns 0x01 when mapper_fixed is set and 0xFF otherwise, with no select. The offset is addr[12:0].
- R4: 0xC000–0xCFFF and 0xE000–0xEFFF select work RAM bank 0 (bit 6). 0xD000–0xDFFF and 0xF000–0xFDFF select the switchable work RAM bank (bit 7). Both use offset addr[11:0].
- R5: 0xFE00–0xFE9F selects the sprite table (bit 8, offset addr[7:0]) only when video_mode is 0 or 1. Otherwise it returns 0xFF with no select.
- R6: 0xFEA0–0xFEFF returns 0xFF with no select, and bad_region pulses high in the acceptance cycle.
- R7: 0xFF00–0xFF7F selects I/O registers (bit 9) and 0xFF80–0xFFFE selects high RAM (bit 10), both with offset addr[6:0]. 0xFFFF selects the interrupt-enable register (bit 11) with offset 0.
- R8: While dma_active is high, the bus of page bits [15:13] follows a table: pages 0–3 and 5 are external, page 4 is video, page 7 is the CPU bus, and page 6 is external, or a separate work-RAM bus when color_model is 1. When the page of dma_src_hi is not the CPU bus and equals the page of the read, the read returns 0xFF with no select.
- R9: While dma_active is high, any read of 0xFE00–0xFE9F returns 0xFF with no select, whatever the video mode.
- R10: A read accepted in cycle T gives rsp_valid in T+1 with the byte on src_rdata in T, or the fixed value. The response holds until rsp_ready. req_ready = !rsp_valid || rsp_ready.
- R11: src_sel has at most one bit set, and only in a cycle where a request is accepted.
- R12: After reset rsp_valid is 0, src_sel is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | CPU read address |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Response byte |
| src_sel | output | 12 | One-hot source strobe (bit map in R1–R7) |
| src_off | output | 14 | Offset within the selected source |
| src_rdata | input | DATA_W | Byte returned by the selected source in the same cycle |
| bad_region | output | 1 | Pulse on acceptance of an unusable-hole read |
| dma_active | input | 1 | Sprite-table DMA has bytes remaining |
| dma_src_hi | input | 3 | DMA source address bits [15:13] |
| color_model | input | 1 | 1 selects the colour-model bus table |
| video_mode | input | 2 | Current video unit mode |
| clk_reg_en | input | 1 | Clock-register access enabled |
| mapper_rd_en | input | 1 | Mapper read handler present |
| sram_en | input | 1 | Cartridge SRAM access enabled |
| sram_present | input | 1 | Cartridge SRAM fitted |
| mapper_fixed | input | 1 | Mapper that answers 0x01 on an empty window |

## Verification
The bench walks every 4 KiB page and the exact edges of the top page: 0xFDFF/0xFE00, 0xFE9F/0xFEA0, 0xFEFF/0xFF00, 0xFF7F/0xFF80 and 0xFFFE/0xFFFF. An off-by-one edge would strobe the wrong source or miss the error pulse. All 32 combinations of the external-RAM flags are tried, so a reordered priority chain shows up as the wrong strobe or the wrong fixed byte. All DMA source pages are crossed with both models and every read page, which exposes a bus table that treats page 6 the same on both models, or one that blocks reads on the CPU bus. Random traffic with a stalling consumer catches a response that changes or is lost while it waits.

// File: rtl/rdsteer_pkg.sv
package rdsteer_pkg;
  localparam int NSRC  = 12;
  localparam int OFF_W = 14;
  localparam int NPAGE = 8;

  typedef enum logic [3:0] {
    SRC_ROM0  = 4'd0,
    SRC_ROMX  = 4'd1,
    SRC_VRAM  = 4'd2,
    SRC_CLK   = 4'd3,
    SRC_MAP   = 4'd4,
    SRC_SRAM  = 4'd5,
    SRC_WRAM0 = 4'd6,
    SRC_WRAMX = 4'd7,
    SRC_OAM   = 4'd8,
    SRC_IO    = 4'd9,
    SRC_HRAM  = 4'd10,
    SRC_IE    = 4'd11,
    SRC_NONE  = 4'd15
  } src_e;

  typedef enum logic [1:0] {
    BUS_CPU = 2'd0,
    BUS_EXT = 2'd1,
    BUS_VID = 2'd2,
    BUS_WRK = 2'd3
  } bus_e;

  typedef struct packed {
    src_e             src;
    logic [OFF_W-1:0] off;
    logic             const_one;
    logic             hole;
  } route_t;

  function automatic bus_e bus_at(input logic [2:0] page, input logic color);
    case (page)
      3'd4:    bus_at = BUS_VID;
      3'd6:    bus_at = color ? BUS_WRK : BUS_EXT;
      3'd7:    bus_at = BUS_CPU;
      default: bus_at = BUS_EXT;
    endcase
  endfunction
endpackage

// File: rtl/rdsteer_region_dec.sv
module rdsteer_region_dec
  import rdsteer_pkg::*;
(
  input  logic [15:0] addr,
  input  logic [1:0]  video_mode,
  input  logic        clk_reg_en,
  input  logic        mapper_rd_en,
  input  logic        sram_en,
  input  logic        sram_present,
  input  logic        mapper_fixed,
  output route_t      route
);
  logic [11:0] low;
  assign low = addr[11:0];

  always_comb begin
    route.src       = SRC_NONE;
    route.off       = '0;
    route.const_one = 1'b0;
    route.hole      = 1'b0;
    case (addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        route.src = SRC_ROM0;
        route.off = addr[13:0];
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        route.src = SRC_ROMX;
        route.off = addr[13:0];
      end
      4'h8, 4'h9: begin
        route.src = SRC_VRAM;
        route.off = OFF_W'(addr[12:0]);
      end
      4'hA, 4'hB: begin
        route.off = OFF_W'(addr[12:0]);
        if (clk_reg_en)                route.src = SRC_CLK;
        else if (mapper_rd_en)         route.src = SRC_MAP;
        else if (sram_en && sram_present) route.src = SRC_SRAM;
        else if (mapper_fixed)         route.const_one = 1'b1;
      end
      4'hC, 4'hE: begin
        route.src = SRC_WRAM0;
        route.off = OFF_W'(low);
      end
      4'hD: begin
        route.src = SRC_WRAMX;
        route.off = OFF_W'(low);
      end
      default: begin
        if (low < 12'hE00) begin
          route.src = SRC_WRAMX;
          route.off = OFF_W'(low);
        end else if (low < 12'hEA0) begin
          if (video_mode < 2'd2) begin
            route.src = SRC_OAM;
            route.off = OFF_W'(low[7:0]);
          end
        end else if (low < 12'hF00) begin
          route.hole = 1'b1;
        end else if (low < 12'hF80) begin
          route.src = SRC_IO;
          route.off = OFF_W'(low[6:0]);
        end else if (low != 12'hFFF) begin
          route.src = SRC_HRAM;
          route.off = OFF_W'(low[6:0]);
        end else begin
          route.src = SRC_IE;
        end
      end
    endcase
  end
endmodule

// File: rtl/rdsteer_dma_guard.sv
module rdsteer_dma_guard
  import rdsteer_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        dma_active,
  input  logic [2:0]  dma_src_hi,
  input  logic        color_model,
  output logic        blocked
);
  bus_e tbl [NPAGE];

  for (genvar g = 0; g < NPAGE; g++) begin : g_tbl
    assign tbl[g] = bus_at(3'(g), color_model);
  end

  bus_e dma_bus, acc_bus;
  logic bus_clash, oam_hit;

  assign dma_bus   = tbl[dma_src_hi];
  assign acc_bus   = tbl[addr[15:13]];
  assign bus_clash = (dma_bus != BUS_CPU) && (dma_bus == acc_bus);
  assign oam_hit   = (addr >= 16'hFE00) && (addr < 16'hFEA0);
  assign blocked   = dma_active && (bus_clash || oam_hit);
endmodule

// File: rtl/rdsteer_rsp_stage.sv
module rdsteer_rsp_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic [DATA_W-1:0] load_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cpu_read_steer.sv
module cpu_read_steer
  import rdsteer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [15:0]           req_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [NSRC-1:0]       src_sel,
  output logic [OFF_W-1:0]      src_off,
  input  logic [DATA_W-1:0]     src_rdata,
  output logic                  bad_region,
  input  logic                  dma_active,
  input  logic [2:0]            dma_src_hi,
  input  logic                  color_model,
  input  logic [1:0]            video_mode,
  input  logic                  clk_reg_en,
  input  logic                  mapper_rd_en,
  input  logic                  sram_en,
  input  logic                  sram_present,
  input  logic                  mapper_fixed
);
  localparam logic [DATA_W-1:0] OPEN_BUS = '1;
  localparam logic [DATA_W-1:0] ONE_VAL  = DATA_W'(1);

  route_t            route;
  logic              blocked;
  logic              accept;
  logic [DATA_W-1:0] load_data;

  rdsteer_region_dec u_dec (
    .addr         (req_addr),
    .video_mode   (video_mode),
    .clk_reg_en   (clk_reg_en),
    .mapper_rd_en (mapper_rd_en),
    .sram_en      (sram_en),
    .sram_present (sram_present),
    .mapper_fixed (mapper_fixed),
    .route        (route)
  );

  rdsteer_dma_guard u_guard (
    .addr        (req_addr),
    .dma_active  (dma_active),
    .dma_src_hi  (dma_src_hi),
    .color_model (color_model),
    .blocked     (blocked)
  );

  rdsteer_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .load_data (load_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    assign src_sel[i] = accept && !blocked && (route.src == src_e'(i));
  end

  assign src_off    = route.off;
  assign bad_region = accept && route.hole;

  always_comb begin
    if (blocked)                 load_data = OPEN_BUS;
    else if (route.src != SRC_NONE) load_data = src_rdata;
    else if (route.const_one)    load_data = ONE_VAL;
    else                         load_data = OPEN_BUS;
  end
endmodule

// File: rtl/rdsteer_chk.sv
module rdsteer_chk #(
  parameter int DATA_W = 8,
  parameter int NSRC   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [15:0]       req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [NSRC-1:0]   src_sel,
  input logic              bad_region,
  input logic              dma_active
);
  logic take;
  logic oam_addr;
  assign take     = req_valid && req_ready;
  assign oam_addr = (req_addr >= 16'hFE00) && (req_addr < 16'hFEA0);

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel));

  // R11
  sel_only_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_sel) |-> take);

  // R10
  take_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R6
  hole_open_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_region |=> (rsp_data == '1));

  // R6
  hole_pulse_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_region |-> (take && (src_sel == '0)));

  // R9
  dma_oam_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dma_active && oam_addr) |-> (src_sel == '0));

  // R9
  dma_oam_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dma_active && oam_addr) |=> (rsp_data == '1));
endmodule

bind cpu_read_steer rdsteer_chk #(.DATA_W(DATA_W), .NSRC(rdsteer_pkg::NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .src_sel    (src_sel),
  .bad_region (bad_region),
  .dma_active (dma_active)
);

// File: tb/cpu_read_steer_test.sv
module cpu_read_steer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic [11:0] src_sel;
  logic [13:0] src_off;
  logic [7:0]  src_rdata;
  logic        bad_region;
  logic        dma_active = 1'b0;
  logic [2:0]  dma_src_hi = '0;
  logic        color_model = 1'b0;
  logic [1:0]  video_mode = '0;
  logic        clk_reg_en = 1'b0, mapper_rd_en = 1'b0, sram_en = 1'b0;
  logic        sram_present = 1'b0, mapper_fixed = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit stall_mode = 0;

  always #10 clk = ~clk;

  cpu_read_steer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .src_sel(src_sel), .src_off(src_off),
    .src_rdata(src_rdata), .bad_region(bad_region), .dma_active(dma_active),
    .dma_src_hi(dma_src_hi), .color_model(color_model), .video_mode(video_mode),
    .clk_reg_en(clk_reg_en), .mapper_rd_en(mapper_rd_en), .sram_en(sram_en),
    .sram_present(sram_present), .mapper_fixed(mapper_fixed)
  );

  // Memory model: byte depends on which source and which offset.
  function automatic logic [7:0] mem_byte(input int idx, input int off);
    return 8'((idx * 29 + off * 7 + 3) & 255);
  endfunction

  always_comb begin
    src_rdata = 8'h5A;
    for (int i = 0; i < 12; i++)
      if (src_sel[i]) src_rdata = mem_byte(i, int'(src_off));
  end

  // Bus classes: 0 cpu, 1 external, 2 video, 3 work RAM
  function automatic int bus_of(input int a);
    if (a < 'h8000) return 1;
    if (a < 'hA000) return 2;
    if (a < 'hC000) return 1;
    if (a < 'hE000) return color_model ? 3 : 1;
    return 0;
  endfunction

  function automatic bit is_blocked(input int a);
    int db;
    if (!dma_active) return 0;
    if (a >= 'hFE00 && a < 'hFEA0) return 1;
    db = bus_of(int'(dma_src_hi) * 'h2000);
    return (db != 0) && (db == bus_of(a));
  endfunction

  function automatic string tag_of(input int a);
    if (dma_active && a >= 'hFE00 && a < 'hFEA0) return "R9";
    if (is_blocked(a)) return "R8";
    if (a < 'h8000) return "R1";
    if (a < 'hA000) return "R2";
    if (a < 'hC000) return "R3";
    if (a < 'hFE00) return "R4";
    if (a < 'hFEA0) return "R5";
    if (a < 'hFF00) return "R6";
    return "R7";
  endfunction

  // sel = -1 means no source; cdat is then the value returned
  task automatic predict(input int a, output int sel, output int off,
                         output int cdat, output bit err);
    sel = -1; off = 0; cdat = 255;
    err = (a >= 'hFEA0 && a < 'hFF00);
    if (is_blocked(a)) return;
    if (a < 'h4000)       begin sel = 0; off = a & 'h3FFF; end
    else if (a < 'h8000)  begin sel = 1; off = a & 'h3FFF; end
    else if (a < 'hA000)  begin sel = 2; off = a & 'h1FFF; end
    else if (a < 'hC000) begin
      off = a & 'h1FFF;
      if (clk_reg_en) sel = 3;
      else if (mapper_rd_en) sel = 4;
      else if (sram_en && sram_present) sel = 5;
      else if (mapper_fixed) cdat = 1;
    end
    else if (a < 'hD000)  begin sel = 6; off = a & 'hFFF; end
    else if (a < 'hE000)  begin sel = 7; off = a & 'hFFF; end
    else if (a < 'hF000)  begin sel = 6; off = a & 'hFFF; end
    else if (a < 'hFE00)  begin sel = 7; off = a & 'hFFF; end
    else if (a < 'hFEA0) begin
      if (video_mode < 2) begin sel = 8; off = a & 'hFF; end
    end
    else if (a < 'hFF00)  begin end
    else if (a < 'hFF80)  begin sel = 9; off = a & 'h7F; end
    else if (a < 'hFFFF)  begin sel = 10; off = a & 'h7F; end
    else                  begin sel = 11; off = 0; end
  endtask

  // Reference response state
  bit       exp_valid = 0;
  int       exp_data = 0;
  string    exp_tag = "R10";

  always @(posedge clk) begin
    int s, o, c; bit e; bit rdy;
    if (!rst_n) begin
      exp_valid <= 0;
      exp_data  <= 0;
    end else begin
      rdy = !exp_valid || rsp_ready;
      predict(int'(req_addr), s, o, c, e);
      if (req_valid && rdy) begin
        exp_valid <= 1;
        exp_data  <= (s >= 0) ? int'(mem_byte(s, o)) : c;
        exp_tag   <= tag_of(int'(req_addr));
      end else if (rsp_ready) begin
        exp_valid <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h addr=0x%04h t=%0t",
               req, what, act, exp, req_addr, $time);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    int s, o, c; bit e; bit rdy, acc; int esel;
    string t;
    if (rst_n) begin
      rdy = !exp_valid || rsp_ready;
      acc = req_valid && rdy;
      predict(int'(req_addr), s, o, c, e);
      t = tag_of(int'(req_addr));
      esel = (acc && s >= 0) ? (1 << s) : 0;
      chk(req_ready == rdy, "R10", "req_ready", int'(req_ready), int'(rdy));
      chk(int'(src_sel) == esel, $sformatf("R11/%s", t), "src_sel",
          int'(src_sel), esel);
      if (esel != 0)
        chk(int'(src_off) == o, t, "src_off", int'(src_off), o);
      chk(bad_region == (acc && e), "R6", "bad_region",
          int'(bad_region), int'(acc && e));
      chk(rsp_valid == exp_valid, "R10", "rsp_valid",
          int'(rsp_valid), int'(exp_valid));
      if (exp_valid)
        chk(int'(rsp_data) == exp_data, $sformatf("R10/%s", exp_tag),
            "rsp_data", int'(rsp_data), exp_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL R10 watchdog: actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic rd(input int a);
    @(posedge clk);
    #1;
    req_addr  = 16'(a);
    req_valid = 1'b1;
    rsp_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
  endtask

  initial begin
    int edges[14];
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    total++;
    if (rsp_valid !== 1'b0 || src_sel !== '0 || req_ready !== 1'b1) begin
      bad++;
      $display("FAIL R12 reset: actual=%b/%h/%b expected=0/000/1",
               rsp_valid, src_sel, req_ready);
    end
    rst_n = 1'b1;

    // Every 4 KiB page, plus edges of the top page
    for (int i = 0; i < 256; i++) rd(i * 256 + ((i * 37) & 255));
    edges = '{'hDFFF, 'hE000, 'hEFFF, 'hF000, 'hFDFF, 'hFE00, 'hFE9F,
              'hFEA0, 'hFEFF, 'hFF00, 'hFF7F, 'hFF80, 'hFFFE, 'hFFFF};
    foreach (edges[k]) rd(edges[k]);

    // R5: sprite table under each video mode
    for (int m = 0; m < 4; m++) begin
      video_mode = 2'(m);
      rd('hFE00); rd('hFE55); rd('hFE9F);
    end
    video_mode = 0;

    // R3: all external-RAM flag combinations
    for (int f = 0; f < 32; f++) begin
      {clk_reg_en, mapper_rd_en, sram_en, sram_present, mapper_fixed} = 5'(f);
      rd('hA123); rd('hBFFF);
    end
    {clk_reg_en, mapper_rd_en, sram_en, sram_present, mapper_fixed} = '0;

    // R8, R9: DMA source pages vs read pages, both models
    dma_active = 1'b1;
    for (int cm = 0; cm < 2; cm++)
      for (int sp = 0; sp < 8; sp++) begin
        color_model = 1'(cm);
        dma_src_hi  = 3'(sp);
        video_mode  = 2'(sp & 1);
        for (int rp = 0; rp < 8; rp++) rd(rp * 'h2000 + 'h0123);
        rd('hFE10); rd('hFEA0); rd('hFF90); rd('hFFFF);
      end
    dma_active = 1'b0;
    color_model = 1'b0;

    // Random traffic with a stalling consumer
    stall_mode = 1;
    for (int n = 0; n < 3000; n++) begin
      dma_active = ($urandom % 4) == 0;
      dma_src_hi = 3'($urandom);
      color_model = 1'($urandom);
      video_mode = 2'($urandom);
      {clk_reg_en, mapper_rd_en, sram_en, sram_present, mapper_fixed} = 5'($urandom);
      if ($urandom % 5 == 0) begin
        @(posedge clk); #1;
        req_valid = 1'b0;
        rsp_ready = 1'($urandom % 2);
      end else begin
        rd(int'($urandom % 65536));
      end
    end
    stall_mode = 0;

    @(posedge clk); #1;
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule